// File: doc/BRIEF.md
# Watchdog Timer with Power-Down Status Flags

This block holds a watchdog counter fed by a programmable prescaler, plus two active-low status flags: a time-out flag and a power-down flag. An instruction decoder issues two requests. A watchdog-clear request restarts the count. A sleep request restarts the count and puts the core into standby. Each request sets the two flags to a different pair of values. After a reset or a wake-up, software reads the pair to learn whether the watchdog fired and whether the core had been asleep.

The counter advances once per prescaled tick. When it wraps past its all-ones value, the time-out flag drops to 0. If the core is awake at that point, the block sends a one-cycle core reset pulse. If the core is asleep, it sends a one-cycle wake pulse and drops the sleep output, which gates the core clock.

Top module: `wdt_pd_ctrl`

## Requirements
- R1: After the synchronous active-low reset, `to_n_o` and `pd_n_o` are 1, `sleep_o`, `core_rst_o` and `wake_o` are 0, and the counter and prescaler are zero.
- R2: An accepted watchdog-clear request zeroes the counter and prescaler. One cycle later both `to_n_o` and `pd_n_o` read 1.
- R3: An accepted sleep request zeroes the counter and prescaler. One cycle later `to_n_o` reads 1, `pd_n_o` reads 0 and `sleep_o` reads 1.
- R4: With `wd_tick_i` held high, an overflow occurs exactly 2^CNT_W × 2^`ratio_sel_i` tick cycles after the cycle that restarted the count. `ratio_sel_i` is 3 bits wide and gives a ratio of 1 to 128.
- R5: An overflow while awake produces a one-cycle `core_rst_o` pulse, sets `to_n_o` to 0 and leaves `pd_n_o` unchanged.
- R6: An overflow while asleep produces a one-cycle `wake_o` pulse instead of a reset. It also clears `sleep_o` and sets `to_n_o` to 0, while `pd_n_o` stays 0.
- R7: While `sleep_o` is 1, both requests are ignored. The flags keep their values and the pending wake time does not move.
- R8: A request that lands in the same cycle as an overflow wins. No reset or wake pulse is produced, and the count restarts.
- R9: If both requests arrive in the same cycle, the sleep request takes effect and the clear request is dropped.
- R10: The prescaler and counter advance only in cycles where `wd_tick_i` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wd_tick_i | input | 1 | Watchdog time-base tick enable |
| ratio_sel_i | input | SEL_W (3) | Prescale ratio exponent, ratio = 2^value |
| clrwdt_req_i | input | 1 | Watchdog-clear request from the decoder |
| sleep_req_i | input | 1 | Sleep request from the decoder |
| to_n_o | output | 1 | Time-out flag, 0 after a watchdog overflow |
| pd_n_o | output | 1 | Power-down flag, 0 after a sleep request |
| sleep_o | output | 1 | Core clock stop request |
| core_rst_o | output | 1 | One-cycle core reset on overflow while awake |
| wake_o | output | 1 | One-cycle wake-up on overflow while asleep |

## Verification
The bench measures the exact overflow period for every prescale ratio. A prescaler that compared against the wrong mask, or missed one tick, would shift the period by a whole factor of two or by one cycle. It places a request on the exact overflow cycle. A design that let the overflow win would emit a stray reset pulse. It also issues a clear during sleep and checks that the wake time is unchanged. A design that honoured that clear would wake late and set the power-down flag back to 1. Two more tests cover simultaneous requests and gaps in the tick. These catch a wrong priority between the requests and a counter that runs without ticks.

// File: rtl/wdt_pkg.sv
// Package: shared helpers for the watchdog block.
// Assumes the prescale exponent never exceeds the prescaler width.
package wdt_pkg;

    // Build a low-order mask of `sel` ones; the prescaler is full when it matches.
    function automatic logic [15:0] ratio_mask(input logic [3:0] sel);
        logic [15:0] m;
        for (int i = 0; i < 16; i++) begin
            m[i] = (i < int'(sel));
        end
        return m;
    endfunction

endpackage

// File: rtl/wdt_prescaler.sv
// Module: tick prescaler dividing the time base by 2^sel_i.
// Assumes sel_i <= PS_W. A clear zeroes the count and suppresses the step.
module wdt_prescaler #(
    parameter int PS_W  = 7,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    input  logic             clear_i,
    output logic             step_o
);
    import wdt_pkg::*;

    logic [PS_W-1:0] pre_q;
    logic [PS_W-1:0] mask;
    logic            full;

    // Select the comparison mask for the current ratio.
    always_comb begin
        logic [15:0] m16;
        m16  = ratio_mask(4'(sel_i));
        mask = m16[PS_W-1:0];
        full = ((pre_q & mask) == mask);
    end

    // A step fires on the tick that fills the prescaler.
    assign step_o = tick_i && full && !clear_i;

    // Advance the prescaler on ticks and restart it on a step or clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            pre_q <= '0;
        end else if (tick_i) begin
            pre_q <= full ? '0 : pre_q + 1'b1;
        end
    end

    // R2
    pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (pre_q == '0));

    // R10
    pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_i && !clear_i) |=> $stable(pre_q));

endmodule

// File: rtl/wdt_counter.sv
// Module: watchdog main counter, advanced by prescaler steps.
// Assumes step_i is already suppressed during a clear. Overflow is a comb pulse.
module wdt_counter #(
    parameter int CNT_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_i,
    input  logic clear_i,
    output logic ovf_o
);
    logic [CNT_W-1:0] cnt_q;

    // The overflow happens on the step that wraps an all-ones count.
    assign ovf_o = step_i && (&cnt_q) && !clear_i;

    // Count steps and wrap naturally; a clear restarts from zero.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (step_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // R2
    cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (cnt_q == '0));

    // R10
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!step_i && !clear_i) |=> $stable(cnt_q));

endmodule

// File: rtl/wdt_status.sv
// Module: request acceptance, active-low status flags, sleep state and event pulses.
// Assumes requests come from the decoder and are ignored while the core sleeps.
module wdt_status (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_req_i,
    input  logic sleep_req_i,
    input  logic ovf_i,
    output logic clear_o,
    output logic to_n_o,
    output logic pd_n_o,
    output logic sleep_o,
    output logic core_rst_o,
    output logic wake_o
);
    logic sleep_acc;
    logic clr_acc;
    logic to_n_q, pd_n_q, sleep_q, rst_q, wake_q;

    // Accept requests only when awake; sleep outranks clear.
    always_comb begin
        sleep_acc = sleep_req_i && !sleep_q;
        clr_acc   = clr_req_i && !sleep_q && !sleep_req_i;
        clear_o   = sleep_acc || clr_acc;
    end

    // Update the flags, the sleep state and the one-cycle event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            to_n_q  <= 1'b1;
            pd_n_q  <= 1'b1;
            sleep_q <= 1'b0;
            rst_q   <= 1'b0;
            wake_q  <= 1'b0;
        end else begin
            rst_q  <= 1'b0;
            wake_q <= 1'b0;
            if (sleep_acc) begin
                to_n_q  <= 1'b1;
                pd_n_q  <= 1'b0;
                sleep_q <= 1'b1;
            end else if (clr_acc) begin
                to_n_q <= 1'b1;
                pd_n_q <= 1'b1;
            end else if (ovf_i) begin
                to_n_q <= 1'b0;
                if (sleep_q) begin
                    wake_q  <= 1'b1;
                    sleep_q <= 1'b0;
                end else begin
                    rst_q <= 1'b1;
                end
            end
        end
    end

    assign to_n_o     = to_n_q;
    assign pd_n_o     = pd_n_q;
    assign sleep_o    = sleep_q;
    assign core_rst_o = rst_q;
    assign wake_o     = wake_q;

    // R2
    clr_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_req_i && !sleep_req_i && !sleep_q) |=> (to_n_q && pd_n_q));

    // R3
    sleep_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sleep_req_i && !sleep_q) |=> (to_n_q && !pd_n_q && sleep_q));

    // R5
    rst_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rst_q |-> (!to_n_q && !wake_q));

    // R6
    wake_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wake_q |-> (!to_n_q && !pd_n_q && !sleep_q));

    // R7
    asleep_pd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_q |=> $stable(pd_n_q));

    // R8
    req_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |=> (!rst_q && !wake_q));

endmodule

// File: rtl/wdt_pd_ctrl.sv
// Module: top of the watchdog and power-down status controller.
// Assumes one request source and a free-running time-base tick enable.
module wdt_pd_ctrl #(
    parameter  int CNT_W = 8,
    parameter  int PS_W  = 7,
    localparam int SEL_W = $clog2(PS_W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wd_tick_i,
    input  logic [SEL_W-1:0] ratio_sel_i,
    input  logic             clrwdt_req_i,
    input  logic             sleep_req_i,
    output logic             to_n_o,
    output logic             pd_n_o,
    output logic             sleep_o,
    output logic             core_rst_o,
    output logic             wake_o
);
    logic clear;
    logic step;
    logic ovf;

    wdt_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_i  (wd_tick_i),
        .sel_i   (ratio_sel_i),
        .clear_i (clear),
        .step_o  (step)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_i  (step),
        .clear_i (clear),
        .ovf_o   (ovf)
    );

    wdt_status u_sts (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_req_i   (clrwdt_req_i),
        .sleep_req_i (sleep_req_i),
        .ovf_i       (ovf),
        .clear_o     (clear),
        .to_n_o      (to_n_o),
        .pd_n_o      (pd_n_o),
        .sleep_o     (sleep_o),
        .core_rst_o  (core_rst_o),
        .wake_o      (wake_o)
    );

    // R9
    both_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clrwdt_req_i && sleep_req_i && !sleep_o) |=> !pd_n_o);

    // R5
    excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(core_rst_o && wake_o));

endmodule

// File: tb/tb_wdt_pd_ctrl.sv
module tb_wdt_pd_ctrl;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       tick = 1;
    logic [2:0] sel = 0;
    logic       clr = 0;
    logic       slp = 0;
    logic       to_n, pd_n, sleep, core_rst, wake;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    wdt_pd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .wd_tick_i(tick), .ratio_sel_i(sel),
        .clrwdt_req_i(clr), .sleep_req_i(slp), .to_n_o(to_n), .pd_n_o(pd_n),
        .sleep_o(sleep), .core_rst_o(core_rst), .wake_o(wake)
    );

    // Vector: {ratio select, expected overflow period in cycles}
    localparam logic [18:0] VEC [8] = '{
        {3'd0, 16'd256},  {3'd3, 16'd2048}, {3'd1, 16'd512},   {3'd7, 16'd32768},
        {3'd2, 16'd1024}, {3'd5, 16'd8192}, {3'd4, 16'd4096},  {3'd6, 16'd16384}
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Issue a one-cycle request; returns after the accepting edge.
    task automatic pulse(input logic c, input logic s);
        clr = c; slp = s;
        @(posedge clk);
        @(negedge clk);
        clr = 0; slp = 0;
    endtask

    // Count edges after the request edge until the given event output is seen.
    task automatic wait_evt(input bit want_wake, output int n);
        n = 0;
        for (int i = 0; i < 40000; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (want_wake ? wake : core_rst) break;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not complete");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 to_n", to_n, 1); chk("R1 pd_n", pd_n, 1);
        chk("R1 sleep", sleep, 0); chk("R1 rst", core_rst, 0); chk("R1 wake", wake, 0);
        rst_n = 1;

        // R4 / R5: period per ratio and reset pulse on awake overflow
        foreach (VEC[v]) begin
            sel = VEC[v][18:16];
            pulse(1, 0);
            chk("R2 to_n after clear", to_n, 1);
            chk("R2 pd_n after clear", pd_n, 1);
            wait_evt(0, n);
            chk("R4 period", n, int'(VEC[v][15:0]));
            chk("R5 to_n after overflow", to_n, 0);
            chk("R5 pd_n unchanged", pd_n, 1);
            chk("R5 no wake", wake, 0);
            @(negedge clk);
            chk("R5 reset one cycle", core_rst, 0);
        end
        sel = 0;

        // R3 / R6: sleep then wake on overflow
        pulse(0, 1);
        chk("R3 to_n", to_n, 1); chk("R3 pd_n", pd_n, 0); chk("R3 sleep", sleep, 1);
        wait_evt(1, n);
        chk("R6 wake period", n, 256);
        chk("R6 no reset", core_rst, 0); chk("R6 sleep low", sleep, 0);
        chk("R6 to_n", to_n, 0); chk("R6 pd_n", pd_n, 0);
        @(negedge clk);
        chk("R6 wake one cycle", wake, 0);

        // R7: requests during sleep ignored
        pulse(0, 1);
        repeat (99) @(negedge clk);
        pulse(1, 0);
        chk("R7 pd_n kept", pd_n, 0);
        chk("R7 sleep kept", sleep, 1);
        wait_evt(1, n);
        chk("R7 wake time unchanged", n + 100, 256);

        // R8: request on the overflow cycle wins
        pulse(1, 0);
        repeat (255) @(negedge clk);
        pulse(1, 0);
        chk("R8 no reset", core_rst, 0);
        chk("R8 to_n", to_n, 1);
        wait_evt(0, n);
        chk("R8 restarted period", n, 256);

        // R9: both requests together act as sleep
        pulse(1, 1);
        chk("R9 pd_n", pd_n, 0); chk("R9 sleep", sleep, 1);
        wait_evt(1, n);
        chk("R9 wake period", n, 256);

        // R10: no ticks, no progress
        pulse(1, 0);
        tick = 0;
        repeat (100) @(negedge clk);
        chk("R10 no reset without ticks", core_rst, 0);
        tick = 1;
        wait_evt(0, n);
        chk("R10 period after gap", n, 256);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule